// File: doc/BRIEF.md
# Gradient Direction and Magnitude Normalizer

This block turns a raw voxel gradient into unit-scaled shading terms. It takes the three unsigned central-difference components of the gradient, together with a coarse description of the gradient length produced by an upstream root-estimation stage. That description has three parts: the exponent parity of the sum of squares, half of that exponent, and six mantissa bits. The parity picks one of two fixed 64-entry reciprocal tables and the mantissa bits index it. The retrieved value is one over the square root of the mantissa bin's midpoint, which corrects the coarse root estimate.

Each component is multiplied by the same reciprocal in one of three parallel lanes. The product is shifted right by the table width plus the half-exponent, then rounded to a 16-bit fraction. The code 65535 means 1.0, and values that would round above it are clamped to that code. A fourth lane forms the sum of squares locally and multiplies it by the reciprocal and by a fixed constant. This yields the gradient length as a 16-bit fraction of the largest length the components can produce.

There is one register stage after the multipliers, so results appear one clock after the sample is accepted. The interface is a plain qualified stream with no back-pressure. A sample is accepted on every clock edge where `in_valid` is high. `out_valid` is high for exactly one cycle per accepted sample. While `in_valid` is low the outputs keep their last value. The consumer must take each result in the cycle it is flagged, because the block has no ready input and cannot stall.

Top module: `gradient_normalizer`

## Requirements
- R1: A sample presented with `in_valid` high at a rising edge produces `out_valid` high after that edge, together with its results. `out_valid` is low after any edge where `in_valid` was low.
- R2: While `in_valid` is low, `dir_x`, `dir_y`, `dir_z` and `mag_norm` keep their previous values.
- R3: During reset (`rst_n` low) all outputs read zero and `out_valid` is low.
- R4: The sum of squares is S = 2^(2·h)·m, where `half_shift` = h and `est_odd` is the parity of floor(log2 S). For an even exponent, m lies in [1,2) and `est_idx` = floor((m−1)·64). For an odd exponent, m lies in [2,4) and `est_idx` = floor((m−2)·32). The entry selected is round(4096/√(bin midpoint)). For example, (1,0,0) gives `dir_x` = 65280 exactly, and (1,1,0) gives `dir_x` = `dir_y` = 46160 exactly.
- R5: Each direction output is round(g·R·2^(16−12−h)), where R is the table entry. It stays within 0.0078 of g/|G| when read as code/65535.
- R6: `mag_norm`/65535 stays within 0.0085 of |G|/(255·√3).
- R7: No result wraps. Any value at or above 65536 is output as 65535, so a single-axis gradient of any size reads near full scale.
- R8: A component of zero gives a direction output of zero, whatever the index, parity and shift inputs are. An all-zero gradient also gives `mag_norm` = 0.
- R9: All three lanes use the same reciprocal and shift. A component at least as large as another therefore never gets a smaller direction output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| grad_x | input | 8 | X gradient component, unsigned |
| grad_y | input | 8 | Y gradient component, unsigned |
| grad_z | input | 8 | Z gradient component, unsigned |
| est_idx | input | 6 | Mantissa bits of the sum of squares below its leading bit |
| est_odd | input | 1 | 1 when the sum-of-squares exponent is odd (selects odd table) |
| half_shift | input | 4 | Sum-of-squares exponent divided by two, rounded down |
| out_valid | output | 1 | Results valid this cycle |
| dir_x | output | 16 | Normalized X direction, 65535 = 1.0 |
| dir_y | output | 16 | Normalized Y direction, 65535 = 1.0 |
| dir_z | output | 16 | Normalized Z direction, 65535 = 1.0 |
| mag_norm | output | 16 | Gradient length as a fraction of the largest possible length |

## Verification
The bench builds the block with its default parameters: 8-bit components, a 6-bit index, 12-bit reciprocals and 16-bit outputs. These sizes are small enough that every single-axis gradient from 1 to 255 can be swept on all three axes. That sweep reaches every half-shift from 0 to 7 and both tables, and it covers the near-unity cases where clamping matters. A seeded pseudo-random set of mixed vectors, the all-maximum vector and the zero vector add the highest shift of 8 and the odd-table bins near the top of the range. Two exact vectors pin down one entry of each table.

// File: rtl/gradnorm_pkg.sv
package gradnorm_pkg;

  // Integer square root, digit by digit, of a 64-bit value.
  function automatic longint unsigned isqrt64(longint unsigned v);
    longint unsigned rem;
    longint unsigned root;
    longint unsigned bitv;
    rem  = v;
    root = 64'd0;
    bitv = 64'h4000_0000_0000_0000;
    for (int k = 0; k < 32; k++) begin
      if (rem >= root + bitv) begin
        rem  = rem - (root + bitv);
        root = (root >> 1) + bitv;
      end else begin
        root = root >> 1;
      end
      bitv = bitv >> 2;
    end
    return root;
  endfunction

  // Reciprocal root of a mantissa bin midpoint, scaled by 2^rw, rounded.
  // Midpoints are expressed in units of 2^-(iw+1).
  function automatic longint unsigned recip_entry(int odd, int idx, int rw, int iw);
    longint unsigned mid;
    longint unsigned num;
    longint unsigned r;
    longint unsigned lim;
    if (odd != 0)
      mid = (64'd1 << (iw + 2)) + 64'd4 * longint'(idx) + 64'd2;
    else
      mid = (64'd1 << (iw + 1)) + 64'd2 * longint'(idx) + 64'd1;
    num = (64'd1 << (2 * rw + iw + 3)) / mid;
    r   = (isqrt64(num) + 64'd1) >> 1;
    lim = (64'd1 << rw) - 64'd1;
    if (r > lim) r = lim;
    return r;
  endfunction

  // Scale constant mapping a length to a fraction of the largest length:
  // round(2^(cs+ow) / sqrt(3*(2^gw-1)^2)).
  function automatic longint unsigned mag_const(int cs, int ow, int gw);
    longint unsigned cmax;
    longint unsigned smax;
    longint unsigned num;
    cmax = (64'd1 << gw) - 64'd1;
    smax = 64'd3 * cmax * cmax;
    num  = (64'd1 << (2 * (cs + ow) + 2)) / smax;
    return (isqrt64(num) + 64'd1) >> 1;
  endfunction

endpackage

// File: rtl/gn_recip_lut.sv
module gn_recip_lut #(
  parameter int IDX_W   = 6,
  parameter int RECIP_W = 12
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               odd,
  output logic [RECIP_W-1:0] recip
);
  import gradnorm_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [RECIP_W-1:0] even_tbl [DEPTH];
  logic [RECIP_W-1:0] odd_tbl  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [RECIP_W-1:0] EV = RECIP_W'(recip_entry(0, i, RECIP_W, IDX_W));
    localparam logic [RECIP_W-1:0] OD = RECIP_W'(recip_entry(1, i, RECIP_W, IDX_W));
    assign even_tbl[i] = EV;
    assign odd_tbl[i]  = OD;
  end

  assign recip = odd ? odd_tbl[idx] : even_tbl[idx];

endmodule

// File: rtl/gn_dir_scale.sv
module gn_dir_scale #(
  parameter int G_W     = 8,
  parameter int RECIP_W = 12,
  parameter int SH_W    = 4,
  parameter int OUT_W   = 16
) (
  input  logic [G_W-1:0]     comp,
  input  logic [RECIP_W-1:0] recip,
  input  logic [SH_W-1:0]    shift,
  output logic [OUT_W-1:0]   dir
);
  localparam int PROD_W = G_W + RECIP_W;
  localparam int WIDE_W = PROD_W + OUT_W + 1;

  logic [PROD_W-1:0] prod;
  logic [7:0]        amt;
  logic [WIDE_W-1:0] widened;
  logic [WIDE_W-1:0] half_lsb;
  logic [WIDE_W-1:0] scaled;

  always_comb begin
    prod     = PROD_W'(comp) * PROD_W'(recip);
    amt      = 8'(RECIP_W) + 8'(shift);
    widened  = WIDE_W'(prod) << OUT_W;
    half_lsb = WIDE_W'(1) << (amt - 8'd1);
    scaled   = (widened + half_lsb) >> amt;
    if (|scaled[WIDE_W-1:OUT_W]) dir = '1;
    else                         dir = scaled[OUT_W-1:0];
  end

endmodule

// File: rtl/gn_mag_scale.sv
module gn_mag_scale #(
  parameter int G_W     = 8,
  parameter int RECIP_W = 12,
  parameter int SH_W    = 4,
  parameter int OUT_W   = 16,
  parameter int CS_W    = 8
) (
  input  logic [G_W-1:0]     gx,
  input  logic [G_W-1:0]     gy,
  input  logic [G_W-1:0]     gz,
  input  logic [RECIP_W-1:0] recip,
  input  logic [SH_W-1:0]    shift,
  output logic [OUT_W-1:0]   mag
);
  import gradnorm_pkg::*;

  localparam int S_W    = 2 * G_W + 2;
  localparam int C_W    = CS_W + OUT_W - G_W + 1;
  localparam int P_W    = S_W + RECIP_W + C_W + 1;
  localparam logic [C_W-1:0] SCALE = C_W'(mag_const(CS_W, OUT_W, G_W));

  logic [S_W-1:0] sum_sq;
  logic [P_W-1:0] prod;
  logic [7:0]     amt;
  logic [P_W-1:0] half_lsb;
  logic [P_W-1:0] scaled;

  always_comb begin
    sum_sq   = S_W'(gx) * S_W'(gx) + S_W'(gy) * S_W'(gy) + S_W'(gz) * S_W'(gz);
    prod     = P_W'(sum_sq) * P_W'(recip) * P_W'(SCALE);
    amt      = 8'(RECIP_W) + 8'(CS_W) + 8'(shift);
    half_lsb = P_W'(1) << (amt - 8'd1);
    scaled   = (prod + half_lsb) >> amt;
    if (|scaled[P_W-1:OUT_W]) mag = '1;
    else                      mag = scaled[OUT_W-1:0];
  end

endmodule

// File: rtl/gradient_normalizer.sv
module gradient_normalizer #(
  parameter int G_W     = 8,
  parameter int IDX_W   = 6,
  parameter int RECIP_W = 12,
  parameter int OUT_W   = 16,
  parameter int CS_W    = 8,
  localparam int S_W    = 2 * G_W + 2,
  localparam int SH_W   = $clog2(S_W / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [G_W-1:0]   grad_x,
  input  logic [G_W-1:0]   grad_y,
  input  logic [G_W-1:0]   grad_z,
  input  logic [IDX_W-1:0] est_idx,
  input  logic             est_odd,
  input  logic [SH_W-1:0]  half_shift,
  output logic             out_valid,
  output logic [OUT_W-1:0] dir_x,
  output logic [OUT_W-1:0] dir_y,
  output logic [OUT_W-1:0] dir_z,
  output logic [OUT_W-1:0] mag_norm
);
  localparam int AXES = 3;

  logic [RECIP_W-1:0] recip;
  logic [G_W-1:0]     comp   [AXES];
  logic [OUT_W-1:0]   dir_nx [AXES];
  logic [OUT_W-1:0]   mag_nx;

  assign comp[0] = grad_x;
  assign comp[1] = grad_y;
  assign comp[2] = grad_z;

  gn_recip_lut #(.IDX_W(IDX_W), .RECIP_W(RECIP_W)) i_lut (
    .idx   (est_idx),
    .odd   (est_odd),
    .recip (recip)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_lane
    gn_dir_scale #(.G_W(G_W), .RECIP_W(RECIP_W), .SH_W(SH_W), .OUT_W(OUT_W)) i_dir (
      .comp  (comp[a]),
      .recip (recip),
      .shift (half_shift),
      .dir   (dir_nx[a])
    );
  end

  gn_mag_scale #(.G_W(G_W), .RECIP_W(RECIP_W), .SH_W(SH_W), .OUT_W(OUT_W), .CS_W(CS_W)) i_mag (
    .gx    (grad_x),
    .gy    (grad_y),
    .gz    (grad_z),
    .recip (recip),
    .shift (half_shift),
    .mag   (mag_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dir_x     <= '0;
      dir_y     <= '0;
      dir_z     <= '0;
      mag_norm  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dir_x    <= dir_nx[0];
        dir_y    <= dir_nx[1];
        dir_z    <= dir_nx[2];
        mag_norm <= mag_nx;
      end
    end
  end

endmodule

// File: rtl/gradient_normalizer_chk.sv
module gradient_normalizer_chk #(
  parameter int G_W   = 8,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [G_W-1:0]   grad_x,
  input logic [G_W-1:0]   grad_y,
  input logic [G_W-1:0]   grad_z,
  input logic             out_valid,
  input logic [OUT_W-1:0] dir_x,
  input logic [OUT_W-1:0] dir_y,
  input logic [OUT_W-1:0] dir_z,
  input logic [OUT_W-1:0] mag_norm
);

  a_r1_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dir_x) && $stable(dir_y) && $stable(dir_z) && $stable(mag_norm)));

  a_r8_zero_x: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_x == '0) |=> dir_x == '0);

  a_r8_zero_y: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_y == '0) |=> dir_y == '0);

  a_r8_zero_z: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_z == '0) |=> dir_z == '0);

  a_r8_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_x == '0 && grad_y == '0 && grad_z == '0) |=> mag_norm == '0);

  a_r9_order_xy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_x >= grad_y) |=> dir_x >= dir_y);

  a_r9_order_yz: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && grad_y >= grad_z) |=> dir_y >= dir_z);

endmodule

bind gradient_normalizer gradient_normalizer_chk #(.G_W(G_W), .OUT_W(OUT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .grad_x    (grad_x),
  .grad_y    (grad_y),
  .grad_z    (grad_z),
  .out_valid (out_valid),
  .dir_x     (dir_x),
  .dir_y     (dir_y),
  .dir_z     (dir_z),
  .mag_norm  (mag_norm)
);

// File: tb/test_gradient_normalizer.sv
module test_gradient_normalizer;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam real TOL_DIR = 0.0078;
  localparam real TOL_MAG = 0.0085;
  localparam real FULL = 65535.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  grad_x = '0, grad_y = '0, grad_z = '0;
  logic [5:0]  est_idx = '0;
  logic        est_odd = 1'b0;
  logic [3:0]  half_shift = '0;
  logic        out_valid;
  logic [15:0] dir_x, dir_y, dir_z, mag_norm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gradient_normalizer i_gradient_normalizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .grad_x(grad_x), .grad_y(grad_y), .grad_z(grad_z),
    .est_idx(est_idx), .est_odd(est_odd), .half_shift(half_shift),
    .out_valid(out_valid), .dir_x(dir_x), .dir_y(dir_y), .dir_z(dir_z),
    .mag_norm(mag_norm)
  );

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_tol(string req, string what, int act, real ref_v, real tol);
    real got;
    real diff;
    checks++;
    got  = act / FULL;
    diff = got - ref_v;
    if (diff < 0.0) diff = -diff;
    if (diff > tol) begin
      failures++;
      $display("FAIL %s %s act=%0d (%f) exp=%f", req, what, act, got, ref_v);
    end
  endtask

  // Upstream root-stage fields, per the definition in R4.
  function automatic void root_fields(input longint s, output int idx, output int odd, output int h);
    int e;
    e = 0;
    if (s == 0) begin
      idx = 0; odd = 0; h = 0;
    end else begin
      for (int k = 0; k < 40; k++) if ((s >> k) != 0) e = k;
      h   = e / 2;
      odd = e % 2;
      idx = int'(((s << (IDX_W - odd)) >> (2 * h)) & 63);
    end
  endfunction

  // Drive one sample, wait one edge, leave results for sampling.
  task automatic push(int gx, int gy, int gz);
    longint s;
    int idx, odd, h;
    s = longint'(gx) * gx + longint'(gy) * gy + longint'(gz) * gz;
    root_fields(s, idx, odd, h);
    @(negedge clk);
    grad_x = 8'(gx); grad_y = 8'(gy); grad_z = 8'(gz);
    est_idx = 6'(idx); est_odd = 1'(odd); half_shift = 4'(h);
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_against_ref(int gx, int gy, int gz, string req);
    real len;
    len = $sqrt(real'(gx * gx + gy * gy + gz * gz));
    chk_eq("R1", "out_valid", int'(out_valid), 1);
    if (len > 0.0) begin
      chk_tol(req, "dir_x", int'(dir_x), gx / len, TOL_DIR);
      chk_tol(req, "dir_y", int'(dir_y), gy / len, TOL_DIR);
      chk_tol(req, "dir_z", int'(dir_z), gz / len, TOL_DIR);
      chk_tol("R6", "mag_norm", int'(mag_norm), len / $sqrt(3.0 * 255.0 * 255.0), TOL_MAG);
    end
  endtask

  task automatic t_reset;
    chk_eq("R3", "out_valid in reset", int'(out_valid), 0);
    chk_eq("R3", "dir_x in reset", int'(dir_x), 0);
    chk_eq("R3", "dir_y in reset", int'(dir_y), 0);
    chk_eq("R3", "dir_z in reset", int'(dir_z), 0);
    chk_eq("R3", "mag_norm in reset", int'(mag_norm), 0);
  endtask

  task automatic t_exact_entries;
    push(1, 0, 0);
    chk_eq("R4", "even entry 0 dir_x", int'(dir_x), 65280);
    chk_eq("R8", "zero y", int'(dir_y), 0);
    chk_eq("R8", "zero z", int'(dir_z), 0);
    push(1, 1, 0);
    chk_eq("R4", "odd entry 0 dir_x", int'(dir_x), 46160);
    chk_eq("R4", "odd entry 0 dir_y", int'(dir_y), 46160);
    chk_eq("R8", "zero z", int'(dir_z), 0);
  endtask

  task automatic t_axis_sweep;
    for (int axis = 0; axis < 3; axis++) begin
      for (int g = 1; g < 256; g++) begin
        int v;
        push(axis == 0 ? g : 0, axis == 1 ? g : 0, axis == 2 ? g : 0);
        check_against_ref(axis == 0 ? g : 0, axis == 1 ? g : 0, axis == 2 ? g : 0, "R5");
        v = axis == 0 ? int'(dir_x) : (axis == 1 ? int'(dir_y) : int'(dir_z));
        chk_tol("R7", "single axis near full scale", v, 1.0, TOL_DIR);
      end
    end
  endtask

  task automatic t_mixed;
    int unsigned seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int gx, gy, gz;
      seed = seed * 32'd1103515245 + 32'd12345; gx = int'((seed >> 16) & 255);
      seed = seed * 32'd1103515245 + 32'd12345; gy = int'((seed >> 16) & 255);
      seed = seed * 32'd1103515245 + 32'd12345; gz = int'((seed >> 16) & 255);
      if (n % 7 == 0) gz = gz >> 4;
      push(gx, gy, gz);
      check_against_ref(gx, gy, gz, "R5");
      if (gx >= gy) chk_eq("R9", "x>=y ordering", int'(dir_x >= dir_y), 1);
      if (gy >= gz) chk_eq("R9", "y>=z ordering", int'(dir_y >= dir_z), 1);
      if (gx >= gz) chk_eq("R9", "x>=z ordering", int'(dir_x >= dir_z), 1);
    end
  endtask

  task automatic t_extremes;
    push(255, 255, 255);
    check_against_ref(255, 255, 255, "R5");
    chk_tol("R7", "max magnitude", int'(mag_norm), 1.0, TOL_MAG);
    chk_eq("R9", "equal x y", int'(dir_x), int'(dir_y));
    @(negedge clk);
    grad_x = '0; grad_y = '0; grad_z = '0;
    est_idx = 6'd63; est_odd = 1'b1; half_shift = 4'd8;
    in_valid = 1'b1;
    @(negedge clk);
    chk_eq("R8", "zero vector dir_x", int'(dir_x), 0);
    chk_eq("R8", "zero vector dir_y", int'(dir_y), 0);
    chk_eq("R8", "zero vector dir_z", int'(dir_z), 0);
    chk_eq("R8", "zero vector mag", int'(mag_norm), 0);
  endtask

  task automatic t_hold;
    int hx, hy, hz, hm;
    push(200, 30, 90);
    check_against_ref(200, 30, 90, "R5");
    hx = int'(dir_x); hy = int'(dir_y); hz = int'(dir_z); hm = int'(mag_norm);
    @(negedge clk);
    in_valid = 1'b0;
    grad_x = 8'd5; grad_y = 8'd250; grad_z = 8'd1;
    est_idx = 6'd17; est_odd = 1'b1; half_shift = 4'd2;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk_eq("R1", "out_valid idle", int'(out_valid), 0);
      chk_eq("R2", "dir_x held", int'(dir_x), hx);
      chk_eq("R2", "dir_y held", int'(dir_y), hy);
      chk_eq("R2", "dir_z held", int'(dir_z), hz);
      chk_eq("R2", "mag held", int'(mag_norm), hm);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R3", "out_valid after reset", int'(out_valid), 0);
    t_exact_entries;
    t_axis_sweep;
    t_mixed;
    t_extremes;
    t_hold;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule